// File: doc/BRIEF.md
# Parallel Port Mode FIFO Controller

This block is the host-side register and FIFO logic of an extended parallel port. A small synchronous host bus (write strobe, read strobe, 2-bit address, byte data) reaches four locations: a mode register, a device control register, a status register and a FIFO address. What the FIFO address does depends on the 3-bit mode. It can be a transmit-only FIFO that is drained by a compatible strobe/busy handshake, a bidirectional extended-mode data FIFO, a loop-back test FIFO, or a fixed configuration byte.

The control register drives the four peripheral control lines and requests the port direction. A rising edge on the acknowledge input can latch an interrupt, which stays set until software reads the status register. Changing the mode empties the FIFO and returns the transmit handshake to idle.

Top module: `ppfifo_ctrl`

## Requirements
- R1: Address 1 reads back as {2'b11, last written bits 5:0}. Writes to bits 7:6 are ignored. Address 0 holds the mode in bits 2:0 and reads back {5'b0, mode}.
- R2: Control bit 3 drives slin_n inverted, bit 2 drives init_n uninverted, bit 1 drives afd_n inverted, and bit 0 drives stb_n inverted while no handshake strobe is active. After reset the register is 0.
- R3: The port is in input direction exactly when control bit 5 is 1 and the mode is neither 000 nor 010. pd_oe is the inverse of the input direction.
- R4: In mode 010, bytes written to address 3 go out on pd_out in write order. Each byte gets a single one-cycle low pulse on stb_n, and no transfer starts while busy is high.
- R5: In mode 011 with output direction, address 3 transmits like R4. With input direction, each pd_in_stb pulse pushes pd_in, host reads of address 3 return those bytes in order, and host writes to address 3 are ignored.
- R6: In mode 110, bytes written to address 3 are read back from it in order. They never produce a strobe, and pd_out shows the oldest stored byte (0x00 when the FIFO is empty).
- R7: In mode 111, address 3 reads 0x10 and writes to it are ignored. In modes 000, 001, 100 and 101, address 3 reads 0x00 and writes are ignored.
- R8: The FIFO holds 16 bytes. Status bit 1 is full and bit 0 is empty. A write when full and a read when empty are dropped, and a read when empty returns 0x00.
- R9: A write to address 0 with a mode different from the current one empties the FIFO and returns the transmit handshake to idle.
- R10: ack_n passes through two synchronising flip-flops. When control bit 4 is 1, a low-to-high transition sets irq, and a high-to-low transition does not. irq stays set until address 2 is read; that read returns irq in bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_wr | input | 1 | Host write strobe |
| hb_rd | input | 1 | Host read strobe (pops the FIFO at address 3) |
| hb_addr | input | 2 | 0 mode, 1 control, 2 status, 3 FIFO/config |
| hb_wdata | input | 8 | Host write data |
| hb_rdata | output | 8 | Host read data for the addressed location |
| pd_out | output | 8 | Byte driven toward the peripheral |
| pd_oe | output | 1 | Data line output enable (1 = output direction) |
| pd_in | input | 8 | Byte presented by the peripheral |
| pd_in_stb | input | 1 | One-cycle pulse: peripheral byte valid |
| busy | input | 1 | Peripheral busy, blocks the start of a transfer |
| ack_n | input | 1 | Asynchronous acknowledge from the peripheral |
| stb_n | output | 1 | Data strobe, active low |
| afd_n | output | 1 | Auto-feed line, active low |
| init_n | output | 1 | Initialise line |
| slin_n | output | 1 | Select-in line, active low |
| irq | output | 1 | Sticky acknowledge interrupt |

## Verification
The hardest situations to reach are the FIFO boundaries combined with mode changes: a FIFO that is holding data, or has a transfer in flight, when the mode register is rewritten. The stimulus holds busy high so that bytes pile up, overfills the test FIFO past 16, then switches modes while it is full. It also sweeps all eight modes against both values of the direction bit, and all 256 control values against the four control lines.

// File: rtl/pp_pkg.sv
package pp_pkg;

  typedef enum logic [2:0] {
    PM_COMPAT = 3'b000,
    PM_BIDIR  = 3'b001,
    PM_CFIFO  = 3'b010,
    PM_ECP    = 3'b011,
    PM_RSV4   = 3'b100,
    PM_RSV5   = 3'b101,
    PM_TEST   = 3'b110,
    PM_CONF   = 3'b111
  } pp_mode_e;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_SETUP = 2'd1,
    TX_PULSE = 2'd2,
    TX_HOLD  = 2'd3
  } tx_state_e;

  localparam logic [1:0] A_MODE = 2'd0;
  localparam logic [1:0] A_CTL  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_FIFO = 2'd3;

  localparam logic [7:0] CFG_ID = 8'h10;

  // Effective input direction: some modes force the port to output.
  function automatic logic pp_dir_in(pp_mode_e m, logic req);
    return req && !(m == PM_COMPAT || m == PM_CFIFO);
  endfunction

  function automatic logic [7:0] pp_ctl_view(logic [5:0] c);
    return {2'b11, c};
  endfunction

endpackage

// File: rtl/pp_fifo.sv
module pp_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty,
  output logic [CW-1:0]    count,
  output logic             acc_push,
  output logic             acc_pop
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign acc_push = push && !full;
  assign acc_pop  = pop && !empty;
  assign head     = mem[rp];

  always_ff @(posedge clk) begin
    if (acc_push && !flush) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (acc_push) wp <= nxt(wp);
      if (acc_pop)  rp <= nxt(rp);
      case ({acc_push, acc_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/pp_tx_hs.sv
module pp_tx_hs
  import pp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       flush,
  input  logic       have_data,
  input  logic       busy,
  input  logic [7:0] head,
  output logic       pop,
  output logic [7:0] data,
  output logic       strobe,
  output logic       active
);

  tx_state_e st;

  assign pop    = (st == TX_IDLE) && enable && have_data && !busy;
  assign strobe = (st == TX_PULSE);
  assign active = (st != TX_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= TX_IDLE;
      data <= '0;
    end else if (flush) begin
      st <= TX_IDLE;
    end else begin
      case (st)
        TX_IDLE: if (pop) begin
          data <= head;
          st   <= TX_SETUP;
        end
        TX_SETUP: st <= TX_PULSE;
        TX_PULSE: st <= TX_HOLD;
        default:  st <= TX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pp_ack_irq.sv
module pp_ack_irq #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_n,
  input  logic en,
  input  logic clr,
  output logic rise,
  output logic irq
);

  logic [SYNC-1:0] sync_q;
  logic            last_q;

  assign rise = sync_q[SYNC-1] && !last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
      irq    <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], ack_n};
      last_q <= sync_q[SYNC-1];
      if (rise && en) irq <= 1'b1;
      else if (clr)   irq <= 1'b0;
    end
  end

endmodule

// File: rtl/ppfifo_ctrl.sv
module ppfifo_ctrl
  import pp_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hb_wr,
  input  logic       hb_rd,
  input  logic [1:0] hb_addr,
  input  logic [7:0] hb_wdata,
  output logic [7:0] hb_rdata,
  output logic [7:0] pd_out,
  output logic       pd_oe,
  input  logic [7:0] pd_in,
  input  logic       pd_in_stb,
  input  logic       busy,
  input  logic       ack_n,
  output logic       stb_n,
  output logic       afd_n,
  output logic       init_n,
  output logic       slin_n,
  output logic       irq
);

  pp_mode_e  mode_q;
  logic [5:0] ctl_q;
  logic [1:0] unused_wbits;

  // Named internal events
  logic wr_mode, wr_ctl, mode_chg, stat_rd;
  logic dir_in, tx_mode, rx_mode, test_mode;
  logic host_push, host_pop, per_push;
  logic f_push, f_pop, f_full, f_empty, f_acc_push, f_acc_pop;
  logic [CW-1:0] f_count;
  logic [7:0] f_head, f_wdata, tx_data;
  logic tx_pop, hs_strobe, tx_active, ack_rise;

  assign unused_wbits = hb_wdata[7:6];

  assign wr_mode  = hb_wr && (hb_addr == A_MODE);
  assign wr_ctl   = hb_wr && (hb_addr == A_CTL);
  assign stat_rd  = hb_rd && (hb_addr == A_STAT);
  assign mode_chg = wr_mode && (pp_mode_e'(hb_wdata[2:0]) != mode_q);

  assign dir_in    = pp_dir_in(mode_q, ctl_q[5]);
  assign tx_mode   = (mode_q == PM_CFIFO) || (mode_q == PM_ECP && !dir_in);
  assign rx_mode   = (mode_q == PM_ECP) && dir_in;
  assign test_mode = (mode_q == PM_TEST);

  assign host_push = hb_wr && (hb_addr == A_FIFO) && (tx_mode || test_mode);
  assign host_pop  = hb_rd && (hb_addr == A_FIFO) && (rx_mode || test_mode);
  assign per_push  = rx_mode && pd_in_stb;
  assign f_push    = host_push || per_push;
  assign f_pop     = host_pop || tx_pop;
  assign f_wdata   = per_push ? pd_in : hb_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PM_COMPAT;
      ctl_q  <= '0;
    end else begin
      if (wr_mode) mode_q <= pp_mode_e'(hb_wdata[2:0]);
      if (wr_ctl)  ctl_q  <= hb_wdata[5:0];
    end
  end

  pp_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (mode_chg),
    .push     (f_push),
    .pop      (f_pop),
    .wdata    (f_wdata),
    .head     (f_head),
    .full     (f_full),
    .empty    (f_empty),
    .count    (f_count),
    .acc_push (f_acc_push),
    .acc_pop  (f_acc_pop)
  );

  pp_tx_hs u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (tx_mode && !mode_chg),
    .flush     (mode_chg),
    .have_data (!f_empty),
    .busy      (busy),
    .head      (f_head),
    .pop       (tx_pop),
    .data      (tx_data),
    .strobe    (hs_strobe),
    .active    (tx_active)
  );

  pp_ack_irq #(.SYNC(2)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .ack_n (ack_n),
    .en    (ctl_q[4]),
    .clr   (stat_rd),
    .rise  (ack_rise),
    .irq   (irq)
  );

  assign pd_oe  = !dir_in;
  assign pd_out = test_mode ? (f_empty ? 8'h00 : f_head) : tx_data;

  assign slin_n = !ctl_q[3];
  assign init_n = ctl_q[2];
  assign afd_n  = !ctl_q[1];
  assign stb_n  = !(ctl_q[0] || hs_strobe);

  always_comb begin
    case (hb_addr)
      A_MODE: hb_rdata = {5'b0, mode_q};
      A_CTL:  hb_rdata = pp_ctl_view(ctl_q);
      A_STAT: hb_rdata = {irq, tx_active, 4'b0, f_full, f_empty};
      default: begin
        if (mode_q == PM_CONF)                             hb_rdata = CFG_ID;
        else if ((rx_mode || test_mode) && !f_empty)       hb_rdata = f_head;
        else                                               hb_rdata = 8'h00;
      end
    endcase
  end

endmodule

// File: rtl/pp_checker.sv
module pp_checker #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    mode,
  input logic          mode_chg,
  input logic          pd_oe,
  input logic          f_full,
  input logic          f_empty,
  input logic [CW-1:0] f_count,
  input logic          f_push,
  input logic          f_pop,
  input logic          hs_strobe,
  input logic          tx_active,
  input logic          irq,
  input logic          stat_rd,
  input logic          ack_rise,
  input logic          irq_en
);

  // R8: write into a full FIFO does not grow it
  a_r8_full_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
    (f_full && f_push && !f_pop && !mode_chg) |=> (f_count == $past(f_count)));

  // R8: read from an empty FIFO does not shrink it
  a_r8_empty_no_shrink: assert property (@(posedge clk) disable iff (!rst_n)
    (f_empty && f_pop && !f_push) |=> f_empty);

  // R9: mode change empties the FIFO and idles the handshake
  a_r9_flush_idle: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (f_empty && !tx_active));

  // R3: modes 000 and 010 always output
  a_r3_forced_out: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b000 || mode == 3'b010) |-> pd_oe);

  // R4: strobe is a single-cycle pulse
  a_r4_strobe_one: assert property (@(posedge clk) disable iff (!rst_n)
    hs_strobe |=> !hs_strobe);

  // R10: interrupt holds until status is read
  a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !stat_rd) |=> irq);

  // R10: interrupt only follows an enabled rising edge
  a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ack_rise && irq_en));

endmodule

bind ppfifo_ctrl pp_checker #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode_q),
  .mode_chg  (mode_chg),
  .pd_oe     (pd_oe),
  .f_full    (f_full),
  .f_empty   (f_empty),
  .f_count   (f_count),
  .f_push    (f_push),
  .f_pop     (f_pop),
  .hs_strobe (hs_strobe),
  .tx_active (tx_active),
  .irq       (irq),
  .stat_rd   (stat_rd),
  .ack_rise  (ack_rise),
  .irq_en    (ctl_q[4])
);

// File: tb/ppfifo_ctrl_tb.sv
module ppfifo_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hb_wr = 1'b0, hb_rd = 1'b0;
  logic [1:0] hb_addr = '0;
  logic [7:0] hb_wdata = '0;
  logic [7:0] hb_rdata, pd_out, pd_in = '0;
  logic       pd_oe, pd_in_stb = 1'b0, busy = 1'b0, ack_n = 1'b1;
  logic       stb_n, afd_n, init_n, slin_n, irq;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] sent [64];
  int nsent = 0;
  logic prev_stb = 1'b1;

  always #5 clk = ~clk;

  ppfifo_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .hb_wr(hb_wr), .hb_rd(hb_rd), .hb_addr(hb_addr),
    .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .pd_out(pd_out), .pd_oe(pd_oe),
    .pd_in(pd_in), .pd_in_stb(pd_in_stb), .busy(busy), .ack_n(ack_n),
    .stb_n(stb_n), .afd_n(afd_n), .init_n(init_n), .slin_n(slin_n), .irq(irq)
  );

  // Record bytes on each falling edge of stb_n
  always @(negedge clk) begin
    if (rst_n && prev_stb && !stb_n && nsent < 64) begin
      sent[nsent] = pd_out;
      nsent = nsent + 1;
    end
    prev_stb = stb_n;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    hb_wr = 1'b1; hb_addr = a; hb_wdata = d;
    @(negedge clk);
    hb_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    hb_rd = 1'b1; hb_addr = a;
    #1 d = hb_rdata;
    @(negedge clk);
    hb_rd = 1'b0;
  endtask

  task automatic per_byte(input logic [7:0] d);
    @(negedge clk);
    pd_in = d; pd_in_stb = 1'b1;
    @(negedge clk);
    pd_in_stb = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int base;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // Reset state (R1, R2, R8, R10)
    rd(2'd1, v); chk("R1 reset ctl", v, 8'hC0);
    rd(2'd0, v); chk("R1 reset mode", v, 8'h00);
    chk("R2 reset pins", {4'b0, stb_n, afd_n, init_n, slin_n}, 8'h0D);
    rd(2'd2, v); chk("R8 reset status", v, 8'h01);
    chk("R10 reset irq", {7'b0, irq}, 8'h00);

    // R1/R2: full control sweep in mode 001
    wr(2'd0, 8'h01);
    for (int i = 0; i < 256; i++) begin
      wr(2'd1, 8'(i));
      rd(2'd1, v);
      chk("R1 ctl readback", v, {2'b11, 6'(i)});
      chk("R2 pins", {4'b0, stb_n, afd_n, init_n, slin_n},
          {4'b0, ~i[0], ~i[1], i[2], ~i[3]});
    end
    wr(2'd1, 8'h00);
    for (int m = 0; m < 8; m++) begin
      wr(2'd0, 8'(m));
      rd(2'd0, v); chk("R1 mode readback", v, 8'(m));
    end

    // R3: direction over all modes
    for (int m = 0; m < 8; m++) begin
      for (int b = 0; b < 2; b++) begin
        wr(2'd0, 8'(m));
        wr(2'd1, b ? 8'h20 : 8'h00);
        chk("R3 pd_oe", {7'b0, pd_oe},
            {7'b0, !(b == 1 && m != 0 && m != 2)});
      end
    end
    wr(2'd1, 8'h00);

    // R4: mode 010 transmit, busy blocks start
    wr(2'd0, 8'h02);
    busy = 1'b1;
    nsent = 0;
    for (int i = 0; i < 5; i++) wr(2'd3, 8'hA0 + 8'(i));
    idle(10);
    chk("R4 busy holds", 8'(nsent), 8'd0);
    busy = 1'b0;
    idle(40);
    chk("R4 sent count", 8'(nsent), 8'd5);
    for (int i = 0; i < 5; i++) chk("R4 order", sent[i], 8'hA0 + 8'(i));
    rd(2'd2, v); chk("R4 drained", v, 8'h01);

    // R5: mode 011 output direction transmits
    wr(2'd0, 8'h03);
    nsent = 0;
    wr(2'd3, 8'h3C);
    idle(12);
    chk("R5 ecp tx count", 8'(nsent), 8'd1);
    chk("R5 ecp tx byte", sent[0], 8'h3C);

    // R5: input direction fills from peripheral
    wr(2'd1, 8'h20);
    wr(2'd3, 8'hEE);
    rd(2'd2, v); chk("R5 host write ignored", v, 8'h01);
    for (int i = 0; i < 4; i++) per_byte(8'h5A + 8'(i));
    for (int i = 0; i < 4; i++) begin
      rd(2'd3, v); chk("R5 rx order", v, 8'h5A + 8'(i));
    end
    rd(2'd2, v); chk("R5 rx empty", v, 8'h01);
    wr(2'd1, 8'h00);

    // R6/R8: test FIFO overfill and drain
    wr(2'd0, 8'h06);
    nsent = 0;
    for (int i = 0; i < 20; i++) wr(2'd3, 8'(i * 7 + 3));
    chk("R6 pd_out head", pd_out, 8'd3);
    rd(2'd2, v); chk("R8 full flag", v, 8'h02);
    for (int i = 0; i < 16; i++) begin
      rd(2'd3, v); chk("R6 loopback", v, 8'(i * 7 + 3));
    end
    rd(2'd3, v); chk("R8 empty read", v, 8'h00);
    rd(2'd2, v); chk("R8 empty flag", v, 8'h01);
    chk("R6 no strobe", 8'(nsent), 8'd0);
    chk("R6 pd_out empty", pd_out, 8'h00);

    // R7: configuration byte
    wr(2'd0, 8'h07);
    rd(2'd3, v); chk("R7 config", v, 8'h10);
    wr(2'd3, 8'h99);
    rd(2'd3, v); chk("R7 config after write", v, 8'h10);
    rd(2'd2, v); chk("R7 write ignored", v, 8'h01);
    wr(2'd0, 8'h04);
    wr(2'd3, 8'h77);
    rd(2'd3, v); chk("R7 unused mode read", v, 8'h00);

    // R9: mode change flushes full FIFO and in-flight transfer
    wr(2'd0, 8'h06);
    for (int i = 0; i < 16; i++) wr(2'd3, 8'hC0 + 8'(i));
    rd(2'd2, v); chk("R9 full before", v, 8'h02);
    wr(2'd0, 8'h01);
    wr(2'd0, 8'h06);
    rd(2'd2, v); chk("R9 flushed", v, 8'h01);
    wr(2'd0, 8'h02);
    nsent = 0;
    base = 0;
    wr(2'd3, 8'h11);
    wr(2'd3, 8'h22);
    wr(2'd0, 8'h06);
    idle(12);
    rd(2'd2, v); chk("R9 tx idle", v, 8'h01);
    chk("R9 at most one strobe", 8'(nsent > 1 ? 1 : base), 8'd0);

    // R10: interrupt on rising acknowledge
    wr(2'd1, 8'h10);
    ack_n = 1'b0; idle(6);
    chk("R10 falling no irq", {7'b0, irq}, 8'h00);
    ack_n = 1'b1; idle(6);
    chk("R10 rising sets irq", {7'b0, irq}, 8'h01);
    idle(10);
    chk("R10 irq sticky", {7'b0, irq}, 8'h01);
    rd(2'd2, v); chk("R10 status bit7", v & 8'h80, 8'h80);
    chk("R10 cleared", {7'b0, irq}, 8'h00);
    wr(2'd1, 8'h00);
    ack_n = 1'b0; idle(6);
    ack_n = 1'b1; idle(6);
    chk("R10 disabled", {7'b0, irq}, 8'h00);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule